// File: doc/BRIEF.md
# Indirect RGB Palette Loader

This block is a 256-entry colour lookup table, 24 bits per entry, that a host fills through two byte-wide registers. One register holds the index of the entry being worked on. The other is a data port: the host writes it three times in a row to deliver the red, green and blue bytes of the selected entry. An internal phase counter tracks which component comes next. The host normally writes the index before each triplet. The first two bytes wait in holding registers. The whole 24-bit entry is written into the table in a single cycle when the blue byte arrives, so a pixel lookup never sees a colour that is only partly updated.

After the blue byte, the index advances by one and wraps from 255 to 0. A host can therefore stream a run of consecutive entries after setting the index only once. Reads of the data port return the stored components in the same red, green, blue order and move the phase and index exactly as writes do. Reads of the index register return the current index. A separate pixel port turns an 8-bit index into a 24-bit colour one clock after the index is presented, on the same clock as the host side.

Top module: `palette_loader`

## Requirements
- R1: After a synchronous active-low reset, the index is 0, the next component is red, every table entry reads as 0x000000, `host_rdata` is 0 and `pix_rgb` is 0.
- R2: A write with `host_sel`=0 loads `host_wdata` into the index and makes red the next component.
- R3: Three data writes (`host_sel`=1) store one entry in red, green, blue order, packed with red in bits 23:16, green in 15:8 and blue in 7:0.
- R4: Data writes of red and green leave the table unchanged; the entry changes only in the cycle of the blue write.
- R5: After the blue component is written or read, the index increases by one, wrapping from 255 to 0, and red becomes the next component.
- R6: Data reads return the current entry's red, green and blue bytes in that order on `host_rdata` one cycle after the read, and advance the phase as writes do.
- R7: A read with `host_sel`=0 returns the current index one cycle later and leaves the index and the phase unchanged.
- R8: `pix_rgb` shows the entry selected by `pix_idx` one clock edge after `pix_idx` is applied.
- R9: Writing the index part-way through a triplet discards the held red and green bytes: the entry is not changed and the next data write is taken as red.
- R10: When `host_wr` and `host_rd` are both high in the same cycle, the write is carried out and the read is ignored: `host_rdata` keeps its value and the phase moves only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the host and pixel sides |
| rst_n | input | 1 | Synchronous reset, active low |
| host_sel | input | 1 | Register select: 0 selects the index register, 1 selects the colour data port |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe, one access per cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered, valid the cycle after a read |
| pix_idx | input | 8 | Pixel lookup index |
| pix_rgb | output | 24 | Registered colour, red in 23:16, green in 15:8, blue in 7:0 |

## Verification
The bench checks the table with the pixel port after a red and a green write and before the blue one. A design that commits each byte as it arrives would show a half-written colour at that point. It sets the index to 255 and loads an entry, which exposes an index that saturates at 255 or fails to wrap to 0. It rewrites the index after two of the three bytes, which exposes a phase counter that a new index does not reset. It also raises a read and a write in the same cycle, which catches a design that lets the read change the read data or advance the phase twice. Data readback checks that the components come back in order and that the index advances after the third read.

// File: rtl/pal_pkg.sv
// Package: shared types and constants for the palette loader.
// Assumes three components per entry, sent and returned in red, green, blue order.
package pal_pkg;

    localparam int COMP_W = 8;
    localparam int NCOMP  = 3;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } comp_phase_t;

endpackage

// File: rtl/pal_sequencer.sv
// Module: holds the current entry index and the component phase.
// Assumes an index write takes priority over a data access in the same cycle,
// and that data_op is high for at most one data access per cycle.
module pal_sequencer
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic [IDX_W-1:0] idx_wdata,
    input  logic             data_op,
    output logic [IDX_W-1:0] cur_idx,
    output comp_phase_t      phase
);

    // Index load, phase advance and auto-increment after the last component.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx <= '0;
            phase   <= PH_RED;
        end else if (idx_wr) begin
            cur_idx <= idx_wdata;
            phase   <= PH_RED;
        end else if (data_op) begin
            if (phase == PH_BLUE) begin
                cur_idx <= cur_idx + 1'b1;
                phase   <= PH_RED;
            end else begin
                phase   <= comp_phase_t'(2'(phase) + 2'd1);
            end
        end
    end

    // R2: an index write loads the index and restarts at red
    p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (cur_idx == $past(idx_wdata)) && (phase == PH_RED));

    // R5: the last component moves to the next entry, wrapping at the top
    p_idx_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_op && !idx_wr && phase == PH_BLUE)
        |=> (cur_idx == IDX_W'($past(cur_idx) + 1'b1)) && (phase == PH_RED));

    // R6: the phase only ever takes the three component values
    p_phase_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phase != comp_phase_t'(2'd3));

endmodule

// File: rtl/pal_stage.sv
// Module: holding registers for all components except the last, and assembly
// of the full entry word. Assumes the first component lands in the top byte.
module pal_stage
    import pal_pkg::*;
#(
    parameter int CW = COMP_W,
    parameter int NC = NCOMP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  comp_phase_t      phase,
    input  logic [CW-1:0]    wdata,
    output logic [NC*CW-1:0] entry
);

    logic [CW-1:0] held [NC-1];

    for (genvar k = 0; k < NC - 1; k++) begin : g_hold
        // Capture the byte written while the phase points at component k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held[k] <= '0;
            end else if (load && int'(phase) == k) begin
                held[k] <= wdata;
            end
        end
        assign entry[(NC-1-k)*CW +: CW] = held[k];
    end

    // The last component comes straight from the bus in the commit cycle.
    assign entry[CW-1:0] = wdata;

endmodule

// File: rtl/pal_table.sv
// Module: the colour table with one write port, one combinational host read
// port and one registered pixel read port. Assumes a single clock. A pixel
// lookup of the entry being written in the same cycle returns the old word.
module pal_table #(
    parameter int IDX_W  = 8,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  haddr,
    output logic [WORD_W-1:0] hword,
    input  logic [IDX_W-1:0]  pidx,
    output logic [WORD_W-1:0] prgb
);

    localparam int DEPTH = 1 << IDX_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Whole-entry write, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered pixel lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prgb <= '0;
        end else begin
            prgb <= mem[pidx];
        end
    end

    // Host-side read of the current entry.
    assign hword = mem[haddr];

    // R3: a commit always carries a known address
    p_commit_addr_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !$isunknown(waddr));

endmodule

// File: rtl/palette_loader.sv
// Module: top of the palette loader. Decodes the host strobes, drives the
// sequencer, stage and table, and registers the host read byte.
// Assumes one host access per cycle; a write wins over a read in the same cycle.
module palette_loader
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_sel,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [COMP_W-1:0]        host_wdata,
    output logic [COMP_W-1:0]        host_rdata,
    input  logic [IDX_W-1:0]         pix_idx,
    output logic [NCOMP*COMP_W-1:0]  pix_rgb
);

    localparam int WORD_W = NCOMP * COMP_W;

    logic              idx_wr, data_wr, data_rd, idx_rd, data_op, commit;
    logic [IDX_W-1:0]  cur_idx;
    comp_phase_t       phase;
    logic [WORD_W-1:0] new_entry;
    logic [WORD_W-1:0] host_word;
    logic [COMP_W-1:0] host_comp;

    // Strobe decode: a write suppresses a read in the same cycle.
    always_comb begin
        idx_wr  = host_wr && !host_sel;
        data_wr = host_wr && host_sel;
        data_rd = host_rd && !host_wr && host_sel;
        idx_rd  = host_rd && !host_wr && !host_sel;
        data_op = data_wr || data_rd;
        commit  = data_wr && (phase == PH_BLUE);
    end

    pal_sequencer #(.IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .idx_wdata (host_wdata[IDX_W-1:0]),
        .data_op   (data_op),
        .cur_idx   (cur_idx),
        .phase     (phase)
    );

    pal_stage #(.CW(COMP_W), .NC(NCOMP)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (data_wr),
        .phase (phase),
        .wdata (host_wdata),
        .entry (new_entry)
    );

    pal_table #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit),
        .waddr (cur_idx),
        .wdata (new_entry),
        .haddr (cur_idx),
        .hword (host_word),
        .pidx  (pix_idx),
        .prgb  (pix_rgb)
    );

    // Pick the component the phase points at, first component in the top byte.
    assign host_comp = host_word[(NCOMP - 1 - int'(phase)) * COMP_W +: COMP_W];

    // Registered host read byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (data_rd) begin
            host_rdata <= host_comp;
        end else if (idx_rd) begin
            host_rdata <= COMP_W'(cur_idx);
        end
    end

    // R10: without a read that is taken, the read byte holds
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && !host_wr) |=> $stable(host_rdata));

    // R4: red or green writes never reach the table
    p_no_early_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && phase != PH_BLUE) |-> !u_table.we);

endmodule

// File: tb/test_palette_loader.sv
`timescale 1ns/1ps
module test_palette_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    palette_loader i_palette_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .pix_idx    (pix_idx),
        .pix_rgb    (pix_rgb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One host cycle: drive on a falling edge, release on the next one.
    task automatic host_cycle(input logic sel, input logic wr, input logic rd, input logic [7:0] d);
        @(negedge clk);
        host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic set_idx(input logic [7:0] v);
        host_cycle(1'b0, 1'b1, 1'b0, v);
    endtask

    task automatic put(input logic [7:0] v);
        host_cycle(1'b1, 1'b1, 1'b0, v);
    endtask

    task automatic expect_idx(input string req, input logic [7:0] exp);
        host_cycle(1'b0, 1'b0, 1'b1, 8'h00);
        check(req, 32'(host_rdata), 32'(exp));
    endtask

    task automatic expect_comp(input string req, input logic [7:0] exp);
        host_cycle(1'b1, 1'b0, 1'b1, 8'h00);
        check(req, 32'(host_rdata), 32'(exp));
    endtask

    // Present an index, check the colour exactly one edge later.
    task automatic expect_pix(input string req, input logic [7:0] idx, input logic [23:0] exp);
        @(negedge clk);
        pix_idx = idx;
        @(negedge clk);
        check(req, 32'(pix_rgb), 32'(exp));
    endtask

    task automatic t_reset;
        check("R1 rdata", 32'(host_rdata), 32'h0);
        check("R1 pix", 32'(pix_rgb), 32'h0);
        expect_pix("R1 entry 0", 8'd0, 24'h0);
        expect_pix("R1 entry 255", 8'd255, 24'h0);
        expect_idx("R1 index", 8'd0);
    endtask

    task automatic t_load;
        set_idx(8'd5);
        put(8'h11); put(8'h22); put(8'h33);
        expect_pix("R3 R8 entry 5", 8'd5, 24'h112233);
        expect_idx("R5 index after blue", 8'd6);
    endtask

    task automatic t_partial;
        set_idx(8'd9);
        put(8'hAA);
        expect_pix("R4 after red", 8'd9, 24'h0);
        put(8'hBB);
        expect_pix("R4 after green", 8'd9, 24'h0);
        put(8'hCC);
        expect_pix("R4 after blue", 8'd9, 24'hAABBCC);
    endtask

    task automatic t_abort;
        set_idx(8'd20);
        put(8'h01); put(8'h02);
        set_idx(8'd20);
        expect_pix("R9 untouched", 8'd20, 24'h0);
        put(8'h0A); put(8'h0B); put(8'h0C);
        expect_pix("R9 restart", 8'd20, 24'h0A0B0C);
        expect_pix("R9 neighbour", 8'd21, 24'h0);
    endtask

    task automatic t_wrap;
        set_idx(8'd255);
        put(8'h44); put(8'h55); put(8'h66);
        expect_pix("R5 entry 255", 8'd255, 24'h445566);
        expect_idx("R5 wrap", 8'd0);
        put(8'h77); put(8'h88); put(8'h99);
        expect_pix("R5 stream to 0", 8'd0, 24'h778899);
        expect_idx("R5 after stream", 8'd1);
    endtask

    task automatic t_readback;
        set_idx(8'd5);
        expect_comp("R6 red", 8'h11);
        expect_comp("R6 green", 8'h22);
        expect_comp("R6 blue", 8'h33);
        expect_idx("R6 index advanced", 8'd6);
    endtask

    task automatic t_idx_read;
        set_idx(8'd7);
        put(8'hD1);
        expect_idx("R7 index", 8'd7);
        put(8'hD2); put(8'hD3);
        expect_pix("R7 phase kept", 8'd7, 24'hD1D2D3);
    endtask

    task automatic t_collide;
        set_idx(8'd40);
        expect_idx("R10 setup", 8'd40);
        host_cycle(1'b1, 1'b1, 1'b1, 8'h55);
        check("R10 rdata held", 32'(host_rdata), 32'd40);
        put(8'h66); put(8'h77);
        expect_pix("R10 write taken", 8'd40, 24'h556677);
        expect_idx("R10 index", 8'd41);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_load;
        t_partial;
        t_abort;
        t_wrap;
        t_readback;
        t_idx_read;
        t_collide;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule